// File: doc/BRIEF.md
# Power-Down Mode Entry Controller

This block holds the power-mode control word of a small processor system and sequences entry into and exit from its low-power states. Software arms one of three power-down modes in a single register: halt, standby and deep power-down. The block changes state only when the core raises a sleep-instruction strobe, which is a wait-for-interrupt or wait-for-event. If no mode is armed when the strobe arrives, the block enters a light sleep state.

While a mode is active, the block drives the oscillator enables and a flash power-off request. It also drives a one-hot power-down request to the regulators. The wake sources it accepts depend on the mode. When the flash comes back on, a settle counter holds the flash-ready output low for a parameterised time, which is 10 microseconds at the default clock.

Entry into standby latches an I/O hold. Software can ask for that hold to outlast the wake. A read-only status bit reports the hold, and a write-one release bit ends it.

Top module: `pwr_mode_ctrl`

Control word layout (32 bits):
- Bits 0, 1 and 2 arm halt, standby and deep respectively.
- Bit 3 is flash-off in halt and bit 4 is flash-off in light sleep.
- Bit 5 is the hold request.
- Bit 6 is the write-one release. It always reads 0.
- Bit 7 is the read-only hold status.
- Bit 8 disables the low-speed internal oscillator in deep power-down (1 = off).
- Bit 9 disables the wake pin in deep power-down (1 = off).
- Bits 12 to 15 are the enables for the high-speed crystal, the low-speed internal oscillator, the high-speed internal oscillator and the 32.768 kHz crystal.
- All other bits read 0.

## Requirements
- R1: After reset the control word reads 0x0000_6000: only the low-speed and high-speed internal oscillators are enabled. The power-down request reads 0, flash_ready_o is 1 and io_hold_o is 0.
- R2: An armed mode is entered only on the clock edge that samples sleep_strobe_i high. With an arm bit set and no strobe, pd_req_o stays 0. pd_req_o bit 0 is halt, bit 1 is standby and bit 2 is deep.
- R3: When several arm bits are set, the strobe selects deep first, then standby, then halt.
- R4: A strobe with no arm bit set enters light sleep: pd_req_o stays 0. Any pending interrupt (irq_i) wakes the block from light sleep.
- R5: flash_pwr_off_o is 1 in halt when bit 3 is 1 and in light sleep when bit 4 is 1. It is always 1 in standby and deep, and it is 0 in the run state.
- R6: Once the flash is powered again, flash_ready_o stays 0 for exactly SETTLE_US × CLK_FREQ_HZ / 10^6 cycles, which is 500 at the defaults. It then rises, and the block returns to the run state.
- R7: Entering standby sets io_hold_o and status bit 7. On the wake edge the hold clears if bit 5 is 0 and stays set if bit 5 is 1.
- R8: Writing 1 to bit 6 outside standby clears the hold. Bit 6 stores nothing and reads 0.
- R9: In deep power-down, wake_pin_i wakes the block only when bit 9 is 0. wake_tmr_i wakes it only when bit 8 is 0.
- R10: irq_i wakes the block from halt and light sleep. It has no effect in standby or deep.
- R11: In halt, standby and deep, the high-speed oscillator enables are forced to 0. In deep, the low-speed internal enable follows the inverse of bit 8. In run, light sleep and settle, all four enables follow the control word.
- R12: Writes to status bit 7, to bit 6 and to reserved bits leave no stored value. The control word changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| sleep_strobe_i | input | 1 | Wait-for-interrupt/event strobe from the core |
| irq_i | input | 1 | Any enabled interrupt pending |
| wake_pin_i | input | 1 | External wake pin |
| wake_tmr_i | input | 1 | Wake-up timer event |
| hxt_en_o | output | 1 | High-speed crystal enable |
| lirc_en_o | output | 1 | Low-speed internal oscillator enable |
| hirc_en_o | output | 1 | High-speed internal oscillator enable |
| lxt_en_o | output | 1 | 32.768 kHz crystal enable |
| pd_req_o | output | 3 | One-hot regulator request: {deep, standby, halt} |
| flash_pwr_off_o | output | 1 | Flash power-off request |
| flash_ready_o | output | 1 | Flash settled and usable |
| io_hold_o | output | 1 | I/O state hold |

## Verification
The hardest situation to reach is a hold that outlives a standby wake and is then released by software. Reaching it takes a full chain of steps: arm standby with the hold request set, strobe, wake through the pin, and let the 500-cycle settle run out. Only then are the write of bit 7 (which must have no effect) and the write-one release applied. The deep power-down gating is also hard to reach, because in deep the block must ignore an interrupt, a disabled pin and a timer whose oscillator is off. The bench first shows that the block stays asleep through all three. It then rewrites bit 8 while the block is still in deep and confirms that the timer now wakes it.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int REG_W = 32;

  localparam int B_ARM_STOP  = 0;
  localparam int B_ARM_STBY  = 1;
  localparam int B_ARM_DEEP  = 2;
  localparam int B_FO_STOP   = 3;
  localparam int B_FO_SLEEP  = 4;
  localparam int B_HOLD_REQ  = 5;
  localparam int B_RELEASE   = 6;
  localparam int B_HELD      = 7;
  localparam int B_LIRC_OFF  = 8;
  localparam int B_WKPIN_OFF = 9;
  localparam int B_HXT       = 12;
  localparam int B_LIRC      = 13;
  localparam int B_HIRC      = 14;
  localparam int B_LXT       = 15;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_STOP   = 3'd2,
    ST_STBY   = 3'd3,
    ST_DEEP   = 3'd4,
    ST_SETTLE = 3'd5
  } pm_state_e;

  typedef struct packed {
    logic hxt_en;
    logic lirc_en;
    logic hirc_en;
    logic lxt_en;
    logic wkpin_off;
    logic lirc_off;
    logic hold_req;
    logic fo_sleep;
    logic fo_stop;
    logic arm_deep;
    logic arm_stby;
    logic arm_stop;
  } pm_cfg_t;

  localparam pm_cfg_t CFG_RST = '{hxt_en: 1'b0, lirc_en: 1'b1, hirc_en: 1'b1,
                                  lxt_en: 1'b0, default: 1'b0};
endpackage

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             io_held_i,
  output pm_cfg_t          cfg_o,
  output logic             release_o,
  output logic [REG_W-1:0] rdata_o
);
  pm_cfg_t cfg_q, cfg_d;
  logic    unused_wbits;

  assign unused_wbits = ^{wdata_i[REG_W-1:16], wdata_i[11:10], wdata_i[B_HELD]};

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      cfg_d.arm_stop  = wdata_i[B_ARM_STOP];
      cfg_d.arm_stby  = wdata_i[B_ARM_STBY];
      cfg_d.arm_deep  = wdata_i[B_ARM_DEEP];
      cfg_d.fo_stop   = wdata_i[B_FO_STOP];
      cfg_d.fo_sleep  = wdata_i[B_FO_SLEEP];
      cfg_d.hold_req  = wdata_i[B_HOLD_REQ];
      cfg_d.lirc_off  = wdata_i[B_LIRC_OFF];
      cfg_d.wkpin_off = wdata_i[B_WKPIN_OFF];
      cfg_d.hxt_en    = wdata_i[B_HXT];
      cfg_d.lirc_en   = wdata_i[B_LIRC];
      cfg_d.hirc_en   = wdata_i[B_HIRC];
      cfg_d.lxt_en    = wdata_i[B_LXT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata_o              = '0;
    rdata_o[B_ARM_STOP]  = cfg_q.arm_stop;
    rdata_o[B_ARM_STBY]  = cfg_q.arm_stby;
    rdata_o[B_ARM_DEEP]  = cfg_q.arm_deep;
    rdata_o[B_FO_STOP]   = cfg_q.fo_stop;
    rdata_o[B_FO_SLEEP]  = cfg_q.fo_sleep;
    rdata_o[B_HOLD_REQ]  = cfg_q.hold_req;
    rdata_o[B_HELD]      = io_held_i;
    rdata_o[B_LIRC_OFF]  = cfg_q.lirc_off;
    rdata_o[B_WKPIN_OFF] = cfg_q.wkpin_off;
    rdata_o[B_HXT]       = cfg_q.hxt_en;
    rdata_o[B_LIRC]      = cfg_q.lirc_en;
    rdata_o[B_HIRC]      = cfg_q.hirc_en;
    rdata_o[B_LXT]       = cfg_q.lxt_en;
  end

  assign cfg_o     = cfg_q;
  assign release_o = we_i & wdata_i[B_RELEASE];

  // Control word only moves on a write (R12)
  p_cfg_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/pwr_flash_settle.sv
module pwr_flash_settle #(
  parameter int SETTLE_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)           cnt_d = CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // Loading the counter must drop readiness on the next edge (R6)
  p_load_blocks_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o);
  // Count proceeds one step per cycle (R6)
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwr_io_hold.sv
module pwr_io_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic exit_i,
  input  logic in_stby_i,
  input  logic hold_req_i,
  input  logic release_i,
  output logic hold_o
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (enter_i)                      hold_d = 1'b1;
    else if (exit_i && !hold_req_i)   hold_d = 1'b0;
    else if (release_i && !in_stby_i) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  // Standby entry latches the hold (R7)
  p_enter_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> hold_q);
  // Hold persists across a wake when requested (R7)
  p_keep_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_i && hold_req_i && hold_q) |=> hold_q);
  // Software release outside standby frees the I/O (R8)
  p_release_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !in_stby_i && !enter_i) |=> !hold_q);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe_i,
  input  logic      irq_i,
  input  logic      wake_pin_i,
  input  logic      wake_tmr_i,
  input  logic      arm_stop_i,
  input  logic      arm_stby_i,
  input  logic      arm_deep_i,
  input  logic      fo_stop_i,
  input  logic      fo_sleep_i,
  input  logic      lirc_off_i,
  input  logic      wkpin_off_i,
  input  logic      settle_done_i,
  output pm_state_e state_o,
  output logic      flash_off_o,
  output logic      settle_load_o,
  output logic      enter_stby_o,
  output logic      exit_stby_o
);
  pm_state_e state_q, state_d;
  logic      wake;
  logic      asleep;

  always_comb begin
    unique case (state_q)
      ST_SLEEP, ST_STOP: wake = wake_pin_i | wake_tmr_i | irq_i;
      ST_STBY:           wake = wake_pin_i | wake_tmr_i;
      ST_DEEP:           wake = (wake_pin_i & ~wkpin_off_i) | (wake_tmr_i & ~lirc_off_i);
      default:           wake = 1'b0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_STOP:          flash_off_o = fo_stop_i;
      ST_SLEEP:         flash_off_o = fo_sleep_i;
      ST_STBY, ST_DEEP: flash_off_o = 1'b1;
      default:          flash_off_o = 1'b0;
    endcase
  end

  assign asleep = (state_q == ST_SLEEP) || (state_q == ST_STOP) ||
                  (state_q == ST_STBY)  || (state_q == ST_DEEP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (strobe_i) begin
          if (arm_deep_i)      state_d = ST_DEEP;
          else if (arm_stby_i) state_d = ST_STBY;
          else if (arm_stop_i) state_d = ST_STOP;
          else                 state_d = ST_SLEEP;
        end
      end
      ST_SETTLE: if (settle_done_i) state_d = ST_RUN;
      default:   if (wake) state_d = flash_off_o ? ST_SETTLE : ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state_o       = state_q;
  assign settle_load_o = asleep & wake & flash_off_o;
  assign enter_stby_o  = (state_q == ST_RUN) && (state_d == ST_STBY);
  assign exit_stby_o   = (state_q == ST_STBY) && wake;

  // No strobe, no entry (R2)
  p_entry_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !strobe_i) |=> (state_q == ST_RUN));
  // Deep wins over the other arm bits (R3)
  p_deep_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && strobe_i && arm_deep_i) |=> (state_q == ST_DEEP));
  // Interrupts do not wake standby (R10)
  p_stby_ignores_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STBY && !wake_pin_i && !wake_tmr_i) |=> (state_q == ST_STBY));
  // Deep wake sources gated by their inverted enables (R9)
  p_deep_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEEP && !(wake_pin_i && !wkpin_off_i) && !(wake_tmr_i && !lirc_off_i))
      |=> (state_q == ST_DEEP));
  // Settle only ends into run (R6)
  p_settle_to_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && settle_done_i) |=> (state_q == ST_RUN));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int SETTLE_US   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        sleep_strobe_i,
  input  logic        irq_i,
  input  logic        wake_pin_i,
  input  logic        wake_tmr_i,
  output logic        hxt_en_o,
  output logic        lirc_en_o,
  output logic        hirc_en_o,
  output logic        lxt_en_o,
  output logic [2:0]  pd_req_o,
  output logic        flash_pwr_off_o,
  output logic        flash_ready_o,
  output logic        io_hold_o
);
  localparam int SETTLE_CYC = (CLK_FREQ_HZ / 1_000_000) * SETTLE_US;

  logic [1:0] rst_sync_q;
  logic       rst_ns;
  pm_cfg_t    cfg;
  logic       release_pulse;
  pm_state_e  state;
  logic       flash_off;
  logic       settle_load;
  logic       settle_done;
  logic       enter_stby;
  logic       exit_stby;
  logic       hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  pwr_mode_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .io_held_i (hold),
    .cfg_o     (cfg),
    .release_o (release_pulse),
    .rdata_o   (reg_rdata_o)
  );

  pwr_mode_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_ns),
    .strobe_i      (sleep_strobe_i),
    .irq_i         (irq_i),
    .wake_pin_i    (wake_pin_i),
    .wake_tmr_i    (wake_tmr_i),
    .arm_stop_i    (cfg.arm_stop),
    .arm_stby_i    (cfg.arm_stby),
    .arm_deep_i    (cfg.arm_deep),
    .fo_stop_i     (cfg.fo_stop),
    .fo_sleep_i    (cfg.fo_sleep),
    .lirc_off_i    (cfg.lirc_off),
    .wkpin_off_i   (cfg.wkpin_off),
    .settle_done_i (settle_done),
    .state_o       (state),
    .flash_off_o   (flash_off),
    .settle_load_o (settle_load),
    .enter_stby_o  (enter_stby),
    .exit_stby_o   (exit_stby)
  );

  pwr_flash_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_ns),
    .load_i (settle_load),
    .done_o (settle_done)
  );

  pwr_io_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_ns),
    .enter_i    (enter_stby),
    .exit_i     (exit_stby),
    .in_stby_i  (state == ST_STBY),
    .hold_req_i (cfg.hold_req),
    .release_i  (release_pulse),
    .hold_o     (hold)
  );

  always_comb begin
    hxt_en_o  = cfg.hxt_en;
    lirc_en_o = cfg.lirc_en;
    hirc_en_o = cfg.hirc_en;
    lxt_en_o  = cfg.lxt_en;
    unique case (state)
      ST_STOP, ST_STBY: begin
        hxt_en_o  = 1'b0;
        hirc_en_o = 1'b0;
      end
      ST_DEEP: begin
        hxt_en_o  = 1'b0;
        hirc_en_o = 1'b0;
        lirc_en_o = ~cfg.lirc_off;
      end
      default: ;
    endcase
  end

  assign pd_req_o        = {state == ST_DEEP, state == ST_STBY, state == ST_STOP};
  assign flash_pwr_off_o = flash_off;
  assign flash_ready_o   = ~flash_off & settle_done;
  assign io_hold_o       = hold;

  // Power-down requests are one-hot (R2)
  p_pd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(pd_req_o));
  // Standby and deep always cut the flash (R5)
  p_flash_off_pd_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (pd_req_o[1] | pd_req_o[2]) |-> (flash_pwr_off_o && !flash_ready_o));
  // Fast oscillators stay off during any power-down (R11)
  p_fast_osc_off_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (pd_req_o != 3'b000) |-> (!hxt_en_o && !hirc_en_o));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int SETTLE = 500;
  localparam logic [31:0] OSC_DEF = 32'h0000_6000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        strobe = 1'b0, irq = 1'b0, wpin = 1'b0, wtmr = 1'b0;
  logic        hxt, lirc, hirc, lxt, foff, fready, ioh;
  logic [2:0]  pd;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .sleep_strobe_i(strobe), .irq_i(irq),
    .wake_pin_i(wpin), .wake_tmr_i(wtmr), .hxt_en_o(hxt), .lirc_en_o(lirc),
    .hirc_en_o(hirc), .lxt_en_o(lxt), .pd_req_o(pd), .flash_pwr_off_o(foff),
    .flash_ready_o(fready), .io_hold_o(ioh)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_strobe(); strobe = 1'b1; step(); strobe = 1'b0; endtask
  task automatic pulse_irq();    irq    = 1'b1; step(); irq    = 1'b0; endtask
  task automatic pulse_pin();    wpin   = 1'b1; step(); wpin   = 1'b0; endtask
  task automatic pulse_tmr();    wtmr   = 1'b1; step(); wtmr   = 1'b0; endtask

  // Called right after the wake edge: counts cycles until flash_ready rises
  task automatic settle_measure(input string req);
    int n = 0;
    chk({req, " flash on after wake"}, 32'(foff), 0);
    while (!fready && n < 3 * SETTLE) begin
      step();
      n++;
    end
    chk({req, " settle cycles"}, n, SETTLE);
    chk({req, " back in run"}, 32'(pd), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset word", reg_rdata, OSC_DEF);
    chk("R1 osc enables", {28'd0, hxt, lirc, hirc, lxt}, 32'b0110);
    chk("R1 pd_req", 32'(pd), 0);
    chk("R1 flash ready", 32'(fready), 1);
    chk("R1 io hold", 32'(ioh), 0);
  endtask

  task automatic t_light_sleep();
    wr(OSC_DEF | 32'h10);
    pulse_strobe();
    chk("R4 sleep no pd_req", 32'(pd), 0);
    chk("R5 sleep flash off", 32'(foff), 1);
    chk("R5 sleep not ready", 32'(fready), 0);
    pulse_irq();
    settle_measure("R4 R6 sleep wake");
  endtask

  task automatic t_halt();
    wr(OSC_DEF | 32'h1000 | 32'h1);
    repeat (5) step();
    chk("R2 armed without strobe", 32'(pd), 0);
    pulse_strobe();
    chk("R2 halt entered", 32'(pd), 32'b001);
    chk("R5 halt flash kept", {30'd0, foff, fready}, 32'b01);
    chk("R11 halt osc", {28'd0, hxt, lirc, hirc, lxt}, 32'b0100);
    pulse_irq();
    chk("R10 irq wakes halt", 32'(pd), 0);
    chk("R11 run osc restored", {28'd0, hxt, lirc, hirc, lxt}, 32'b1110);
    wr(OSC_DEF | 32'h9);
    pulse_strobe();
    chk("R5 halt flash off", 32'(foff), 1);
    pulse_tmr();
    settle_measure("R6 halt wake");
  endtask

  task automatic t_priority();
    wr(OSC_DEF | 32'h7);
    pulse_strobe();
    chk("R3 deep first", 32'(pd), 32'b100);
    chk("R5 deep flash off", 32'(foff), 1);
    pulse_pin();
    settle_measure("R3 deep wake");
    wr(OSC_DEF | 32'h3);
    pulse_strobe();
    chk("R3 standby over halt", 32'(pd), 32'b010);
    pulse_pin();
    chk("R7 hold auto released", 32'(ioh), 0);
    settle_measure("R3 standby wake");
  endtask

  task automatic t_deep_gating();
    wr(OSC_DEF | 32'h4 | 32'h100 | 32'h200);
    pulse_strobe();
    chk("R9 deep entered", 32'(pd), 32'b100);
    chk("R11 deep lirc off", 32'(lirc), 0);
    pulse_irq();
    chk("R10 irq ignored in deep", 32'(pd), 32'b100);
    pulse_pin();
    chk("R9 disabled pin ignored", 32'(pd), 32'b100);
    pulse_tmr();
    chk("R9 timer without lirc ignored", 32'(pd), 32'b100);
    wr(OSC_DEF | 32'h4 | 32'h200);
    chk("R11 deep lirc on", 32'(lirc), 1);
    pulse_tmr();
    settle_measure("R9 timer wake");
    wr(OSC_DEF);
  endtask

  task automatic t_io_hold();
    wr(OSC_DEF | 32'h2);
    pulse_strobe();
    chk("R7 hold on entry", 32'(ioh), 1);
    chk("R7 status bit7", 32'(reg_rdata[7]), 1);
    pulse_irq();
    chk("R10 irq ignored in standby", 32'(pd), 32'b010);
    pulse_pin();
    chk("R7 hold cleared without req", 32'(ioh), 0);
    settle_measure("R7 wake");
    wr(OSC_DEF | 32'h22);
    pulse_strobe();
    pulse_pin();
    settle_measure("R7 wake with req");
    chk("R7 hold kept after wake", 32'(ioh), 1);
    wr(OSC_DEF | 32'h20 | 32'h80);
    chk("R12 status write ignored", 32'(ioh), 1);
    chk("R12 word after write", reg_rdata, OSC_DEF | 32'hA0);
    wr(OSC_DEF | 32'h40);
    chk("R8 release clears hold", 32'(ioh), 0);
    chk("R8 release not stored", reg_rdata, OSC_DEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_light_sleep();
    t_halt();
    t_priority();
    t_deep_gating();
    t_io_hold();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule